// File: doc/BRIEF.md
# Multi-Mode High-Speed Event Counter

This block counts fast external pulses into a 32-bit signed register. It has four clocking modes, selected by a static configuration pin. In the first, one pulse input counts in a direction that software holds. In the second, a second pin gives the direction. In the third, separate up and down pulse inputs are used. The fourth decodes an A/B quadrature pair on every edge. An optional level-sensitive reset pin clears the count and holds it at zero for as long as the pin is active. The count is always visible on an output and keeps running while it is read. The pulse inputs are assumed to be synchronous to the block clock already.

A controller changes the counter through a command channel. A single command can carry three updates: a new direction, a new count and a new reference value. Each update has its own flag, and the block applies every flagged field at the same clock edge. The block checks each command and returns a 16-bit status word on a response channel. Any error rejects the whole command, and no field is applied.

Both channels use valid/ready. A command is taken on an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever no response is waiting, or when the waiting response is being taken in the same cycle. A response stays valid, with a stable status, until `rsp_ready` is seen high. The block also raises three one-cycle event pulses:
- the count reaches the reference value;
- the reset pin becomes active;
- the counting direction flips.

Top module: `evt_counter_top`

## Requirements
- R1: After reset the block is in its idle state.
  - `count` is 0 and `count_up` is 1.
  - `rsp_valid` and all three event outputs are 0.
  - `cmd_ready` is 1.
- R2: In mode 0 (`cfg_mode`=0), each rising edge of `in_a` moves the count by one, in the direction held in `count_up` (1 = up). Falling edges and `in_b` have no effect.
- R3: In mode 1, each rising edge of `in_a` moves the count by one. The count goes up if `in_b` is 1 in that cycle and down if `in_b` is 0. `count_up` follows the direction of the last step.
- R4: In mode 2, a rising edge of `in_a` alone counts up and a rising edge of `in_b` alone counts down. Rising edges on both inputs in the same cycle leave the count unchanged.
- R5: In mode 3, the phase pair is turned into an index {`in_b`, `in_a`^`in_b`}.
  - The new index minus the old index, modulo 4, decides the step.
  - A difference of 1 counts up and a difference of 3 counts down.
  - A difference of 2 (both phases changed at once) or 0 leaves the count unchanged.
- R6: The reset pin acts only when `cfg_rst_en` is 1.
  - While `cfg_rst_en` and `in_rst` are both 1, the count is 0 and stays 0 whatever the pulses do.
  - `evt_reset` pulses for one cycle when that hold begins.
  - When `cfg_rst_en` is 0, `in_rst` is ignored.
- R7: A command applies its fields according to the flags `cmd_set_dir`, `cmd_set_cnt` and `cmd_set_ref`.
  - Every flagged field takes effect at the edge that accepts the command, and the new values show at that edge.
  - Data for a field whose flag is low is ignored.
- R8: The new direction is a 16-bit signed value: 16'h0001 means up and 16'hFFFF means down.
  - Any other value, when its flag is set, gives status 16'h80B1.
  - A valid direction request changes `count_up` only in mode 0. In the other modes the request returns status 0 and changes nothing.
- R9: Status values are checked in this priority order, and any nonzero status applies no field:
  - 16'h80A1 when `cmd_id` differs from the unit identifier;
  - 16'h80D0 when `cfg_enable` is 0;
  - 16'h80C0 when the reset pin is holding the count;
  - 16'h80B1 for a bad direction;
  - 0 otherwise.

  While `cfg_enable` is 0, pulses do not change the count.
- R10: `cmd_ready` equals (not `rsp_valid`) or `rsp_ready`. A response waiting with `rsp_ready` low keeps `rsp_valid` high and `rsp_status` stable.
- R11: `evt_match` pulses for one cycle, together with the new count, when a counting step makes the count equal to the reference. A count load does not raise it.
- R12: `evt_dir` pulses for one cycle, together with the new `count_up`, whenever `count_up` changes value.
- R13: The count wraps in two's complement: one step up from 32'h7FFFFFFF gives 32'h80000000, and one step down from 0 gives 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Counter enabled |
| cfg_mode | input | 2 | Clocking mode 0..3 |
| cfg_rst_en | input | 1 | Allow the reset pin to act |
| in_a | input | 1 | Pulse input A (clock, up clock or phase A) |
| in_b | input | 1 | Pulse input B (direction, down clock or phase B) |
| in_rst | input | 1 | Level-sensitive count reset pin |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_id | input | ID_W | Target counter identifier |
| cmd_set_dir | input | 1 | Apply new direction |
| cmd_set_cnt | input | 1 | Apply new count |
| cmd_set_ref | input | 1 | Apply new reference |
| cmd_dir | input | DIR_W | New direction, +1 or -1 |
| cmd_cnt | input | CNT_W | New count value |
| cmd_ref | input | CNT_W | New reference value |
| rsp_valid | output | 1 | Status word available |
| rsp_ready | input | 1 | Status word taken |
| rsp_status | output | 16 | Status code of the last command |
| count | output | CNT_W | Running signed count |
| count_up | output | 1 | Current direction, 1 = up |
| evt_match | output | 1 | Count reached reference |
| evt_reset | output | 1 | Reset hold began |
| evt_dir | output | 1 | Direction flipped |

## Verification
The bench builds the block with its default parameters: a 32-bit count, a 16-bit direction field, a 4-bit identifier and unit identifier 1. The full 32-bit width lets loads at the signed limits exercise the wrap in both directions. For quadrature mode, the bench walks all sixteen pairs of old and new phase states and predicts each step from the index difference. The other modes get every rising-edge combination of the two inputs. The 4-bit identifier allows a mismatched identifier to be sent alone, and also together with a disabled counter, which checks the status priority.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  typedef enum logic [1:0] {
    MODE_SW_DIR  = 2'd0,
    MODE_PIN_DIR = 2'd1,
    MODE_UP_DN   = 2'd2,
    MODE_QUAD    = 2'd3
  } clk_mode_e;

  localparam int STAT_W = 16;
  localparam logic [STAT_W-1:0] STAT_OK      = 16'h0000;
  localparam logic [STAT_W-1:0] STAT_BAD_ID  = 16'h80A1;
  localparam logic [STAT_W-1:0] STAT_BAD_DIR = 16'h80B1;
  localparam logic [STAT_W-1:0] STAT_BUSY    = 16'h80C0;
  localparam logic [STAT_W-1:0] STAT_OFF     = 16'h80D0;
endpackage

// File: rtl/evt_edge_decoder.sv
module evt_edge_decoder
  import evt_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  clk_mode_e  mode,
  input  logic       sw_up,
  input  logic       pin_a,
  input  logic       pin_b,
  output logic       step_up,
  output logic       step_dn
);
  logic prev_a, prev_b;
  logic rise_a, rise_b;
  logic [1:0] idx_old, idx_new, idx_diff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
    end else begin
      prev_a <= pin_a;
      prev_b <= pin_b;
    end
  end

  assign rise_a   = pin_a & ~prev_a;
  assign rise_b   = pin_b & ~prev_b;
  assign idx_old  = {prev_b, prev_a ^ prev_b};
  assign idx_new  = {pin_b, pin_a ^ pin_b};
  assign idx_diff = idx_new - idx_old;

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    unique case (mode)
      MODE_SW_DIR: begin
        step_up = rise_a & sw_up;
        step_dn = rise_a & ~sw_up;
      end
      MODE_PIN_DIR: begin
        step_up = rise_a & pin_b;
        step_dn = rise_a & ~pin_b;
      end
      MODE_UP_DN: begin
        step_up = rise_a & ~rise_b;
        step_dn = rise_b & ~rise_a;
      end
      MODE_QUAD: begin
        step_up = (idx_diff == 2'd1);
        step_dn = (idx_diff == 2'd3);
      end
      default: ;
    endcase
  end

  assert_one_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));
endmodule

// File: rtl/evt_cmd_unit.sv
module evt_cmd_unit
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIR_W = 16,
  parameter int ID_W  = 4,
  parameter logic [ID_W-1:0] UNIT_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  clk_mode_e         mode,
  input  logic              rst_hold,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic              cmd_set_dir,
  input  logic              cmd_set_cnt,
  input  logic              cmd_set_ref,
  input  logic [DIR_W-1:0]  cmd_dir,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [STAT_W-1:0] rsp_status,
  output logic              load_dir,
  output logic              load_dir_up,
  output logic              load_cnt,
  output logic              load_ref
);
  localparam logic [DIR_W-1:0] DIR_FWD = DIR_W'(1);
  localparam logic [DIR_W-1:0] DIR_REV = '1;

  logic              accept;
  logic              dir_ok;
  logic [STAT_W-1:0] verdict;
  logic              good;
  logic              rsp_valid_q;
  logic [STAT_W-1:0] rsp_status_q;

  assign dir_ok    = (cmd_dir == DIR_FWD) || (cmd_dir == DIR_REV);
  assign cmd_ready = ~rsp_valid_q | rsp_ready;
  assign accept    = cmd_valid & cmd_ready;

  always_comb begin
    if (cmd_id != UNIT_ID)            verdict = STAT_BAD_ID;
    else if (!enable)                 verdict = STAT_OFF;
    else if (rst_hold)                verdict = STAT_BUSY;
    else if (cmd_set_dir && !dir_ok)  verdict = STAT_BAD_DIR;
    else                              verdict = STAT_OK;
  end

  assign good        = accept && (verdict == STAT_OK);
  assign load_cnt    = good & cmd_set_cnt;
  assign load_ref    = good & cmd_set_ref;
  assign load_dir    = good & cmd_set_dir & (mode == MODE_SW_DIR);
  assign load_dir_up = (cmd_dir == DIR_FWD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= STAT_OK;
    end else if (accept) begin
      rsp_valid_q  <= 1'b1;
      rsp_status_q <= verdict;
    end else if (rsp_ready) begin
      rsp_valid_q  <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));

  assert_no_apply_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cnt || load_ref || load_dir) |=> (rsp_valid && rsp_status == STAT_OK));
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  clk_mode_e        mode,
  input  logic             rst_hold,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             load_dir,
  input  logic             load_dir_up,
  input  logic             load_cnt,
  input  logic [CNT_W-1:0] new_cnt,
  input  logic             load_ref,
  input  logic [CNT_W-1:0] new_ref,
  output logic [CNT_W-1:0] count_q,
  output logic             dir_q,
  output logic             evt_match,
  output logic             evt_reset,
  output logic             evt_dir
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] ref_q, count_next, ref_next;
  logic             dir_next;
  logic             hold_prev;
  logic             counted;

  assign counted  = enable & ~rst_hold & ~load_cnt & (step_up | step_dn);
  assign ref_next = load_ref ? new_ref : ref_q;

  always_comb begin
    if (rst_hold)       count_next = '0;
    else if (load_cnt)  count_next = new_cnt;
    else if (counted)   count_next = step_up ? count_q + ONE : count_q - ONE;
    else                count_next = count_q;
  end

  always_comb begin
    if (load_dir)
      dir_next = load_dir_up;
    else if (counted && mode != MODE_SW_DIR)
      dir_next = step_up;
    else
      dir_next = dir_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      ref_q     <= '0;
      dir_q     <= 1'b1;
      hold_prev <= 1'b0;
      evt_match <= 1'b0;
      evt_reset <= 1'b0;
      evt_dir   <= 1'b0;
    end else begin
      count_q   <= count_next;
      ref_q     <= ref_next;
      dir_q     <= dir_next;
      hold_prev <= rst_hold;
      evt_match <= counted && (count_next == ref_next);
      evt_reset <= rst_hold & ~hold_prev;
      evt_dir   <= (dir_next != dir_q);
    end
  end

  assert_rst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hold |=> (count_q == '0));

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_hold && !load_cnt) |=> ((count_q == $past(count_q)) ||
                                  (count_q == $past(count_q) + ONE) ||
                                  (count_q == $past(count_q) - ONE)));

  assert_match_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_match |-> (count_q == ref_q));

  assert_dir_flip_R12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_dir |-> (dir_q != $past(dir_q)));
endmodule

// File: rtl/evt_counter_top.sv
module evt_counter_top
  import evt_cnt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIR_W = 16,
  parameter int ID_W  = 4,
  parameter logic [ID_W-1:0] UNIT_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_rst_en,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic              cmd_set_dir,
  input  logic              cmd_set_cnt,
  input  logic              cmd_set_ref,
  input  logic [DIR_W-1:0]  cmd_dir,
  input  logic [CNT_W-1:0]  cmd_cnt,
  input  logic [CNT_W-1:0]  cmd_ref,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [STAT_W-1:0] rsp_status,
  output logic [CNT_W-1:0]  count,
  output logic              count_up,
  output logic              evt_match,
  output logic              evt_reset,
  output logic              evt_dir
);
  clk_mode_e mode;
  logic rst_hold;
  logic step_up, step_dn;
  logic load_dir, load_dir_up, load_cnt, load_ref;

  assign mode     = clk_mode_e'(cfg_mode);
  assign rst_hold = cfg_rst_en & in_rst;

  evt_edge_decoder u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .sw_up   (count_up),
    .pin_a   (in_a),
    .pin_b   (in_b),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  evt_cmd_unit #(
    .CNT_W(CNT_W), .DIR_W(DIR_W), .ID_W(ID_W), .UNIT_ID(UNIT_ID)
  ) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .mode        (mode),
    .rst_hold    (rst_hold),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_id      (cmd_id),
    .cmd_set_dir (cmd_set_dir),
    .cmd_set_cnt (cmd_set_cnt),
    .cmd_set_ref (cmd_set_ref),
    .cmd_dir     (cmd_dir),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_status  (rsp_status),
    .load_dir    (load_dir),
    .load_dir_up (load_dir_up),
    .load_cnt    (load_cnt),
    .load_ref    (load_ref)
  );

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .mode        (mode),
    .rst_hold    (rst_hold),
    .step_up     (step_up),
    .step_dn     (step_dn),
    .load_dir    (load_dir),
    .load_dir_up (load_dir_up),
    .load_cnt    (load_cnt),
    .new_cnt     (cmd_cnt),
    .load_ref    (load_ref),
    .new_ref     (cmd_ref),
    .count_q     (count),
    .dir_q       (count_up),
    .evt_match   (evt_match),
    .evt_reset   (evt_reset),
    .evt_dir     (evt_dir)
  );

  assert_ready_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid) |-> cmd_ready);
endmodule

// File: tb/sim_evt_counter_top.sv
module sim_evt_counter_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_rst_en = 1'b0;
  logic        in_a = 1'b0, in_b = 1'b0, in_rst = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_id = 4'd1;
  logic        cmd_set_dir = 1'b0, cmd_set_cnt = 1'b0, cmd_set_ref = 1'b0;
  logic [15:0] cmd_dir = 16'h0001;
  logic [31:0] cmd_cnt = '0, cmd_ref = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_status;
  logic [31:0] count;
  logic        count_up, evt_match, evt_reset, evt_dir;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] expc;
  logic [1:0]  cur_ab;

  always #5 clk = ~clk;

  evt_counter_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .cfg_rst_en(cfg_rst_en), .in_a(in_a), .in_b(in_b), .in_rst(in_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_id(cmd_id),
    .cmd_set_dir(cmd_set_dir), .cmd_set_cnt(cmd_set_cnt), .cmd_set_ref(cmd_set_ref),
    .cmd_dir(cmd_dir), .cmd_cnt(cmd_cnt), .cmd_ref(cmd_ref),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .count(count), .count_up(count_up), .evt_match(evt_match),
    .evt_reset(evt_reset), .evt_dir(evt_dir)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk);
    in_a = a;
    in_b = b;
    @(negedge clk);
  endtask

  task automatic send(input logic [3:0] id, input logic sd, input logic sc, input logic sr,
                      input logic [15:0] d, input logic [31:0] c, input logic [31:0] r);
    @(negedge clk);
    cmd_id = id; cmd_set_dir = sd; cmd_set_cnt = sc; cmd_set_ref = sr;
    cmd_dir = d; cmd_cnt = c; cmd_ref = r; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [1:0] qidx(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 idle state
    check("R1 count", count, 0);
    check("R1 count_up", {31'd0, count_up}, 1);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    check("R1 events", {29'd0, evt_match, evt_reset, evt_dir}, 0);
    check("R1 cmd_ready", {31'd0, cmd_ready}, 1);

    // R2 software direction mode
    for (int i = 1; i <= 5; i++) begin
      pins(1'b1, 1'b1);
      check("R2 rise", count, i);
      pins(1'b0, 1'b0);
      check("R2 fall", count, i);
    end
    // R8 / R12 direction -1
    send(4'd1, 1, 0, 0, 16'hFFFF, 0, 0);
    check("R8 status", {16'd0, rsp_status}, 0);
    check("R8 dir down", {31'd0, count_up}, 0);
    check("R12 evt_dir", {31'd0, evt_dir}, 1);
    for (int i = 0; i < 3; i++) begin
      pins(1'b1, 1'b0);
      pins(1'b0, 1'b0);
    end
    check("R2 down", count, 2);
    // R8 illegal direction rejects everything
    send(4'd1, 1, 1, 0, 16'h0002, 32'd77, 0);
    check("R8 bad dir status", {16'd0, rsp_status}, 32'h80B1);
    check("R8 bad dir no load", count, 2);
    check("R8 bad dir keeps dir", {31'd0, count_up}, 0);
    // R7 all three fields in one command
    send(4'd1, 1, 1, 1, 16'h0001, 32'd100, 32'd103);
    check("R7 multi status", {16'd0, rsp_status}, 0);
    check("R7 multi count", count, 100);
    check("R7 multi dir", {31'd0, count_up}, 1);
    // R11 match
    pins(1'b1, 1'b0); check("R11 no match 101", {31'd0, evt_match}, 0);
    pins(1'b0, 1'b0);
    pins(1'b1, 1'b0); check("R11 no match 102", {31'd0, evt_match}, 0);
    pins(1'b0, 1'b0);
    pins(1'b1, 1'b0); check("R11 match", {31'd0, evt_match}, 1);
    check("R11 count", count, 103);
    pins(1'b0, 1'b0); check("R11 one cycle", {31'd0, evt_match}, 0);
    // R7 unflagged fields ignored
    send(4'd1, 0, 0, 0, 16'hFFFF, 32'd7, 32'd7);
    check("R7 noflag count", count, 103);
    check("R7 noflag dir", {31'd0, count_up}, 1);
    send(4'd1, 0, 1, 0, 16'h0001, 32'd102, 32'd50);
    check("R7 count only", count, 102);
    check("R11 load no match", {31'd0, evt_match}, 0);
    pins(1'b1, 1'b0); check("R7 ref kept", {31'd0, evt_match}, 1);
    pins(1'b0, 1'b0);
    // R9 status priority
    send(4'd2, 0, 1, 0, 16'h0001, 32'd9, 0);
    check("R9 bad id", {16'd0, rsp_status}, 32'h80A1);
    check("R9 bad id no load", count, 103);
    @(negedge clk); cfg_enable = 1'b0;
    send(4'd1, 0, 1, 0, 16'h0001, 32'd9, 0);
    check("R9 disabled", {16'd0, rsp_status}, 32'h80D0);
    send(4'd3, 0, 1, 0, 16'h0001, 32'd9, 0);
    check("R9 id over disabled", {16'd0, rsp_status}, 32'h80A1);
    pins(1'b1, 1'b0); pins(1'b0, 1'b0);
    check("R9 disabled frozen", count, 103);
    @(negedge clk); cfg_enable = 1'b1;
    // R6 reset pin
    @(negedge clk); in_rst = 1'b1;
    pins(1'b1, 1'b0); pins(1'b0, 1'b0);
    check("R6 pin ignored", count, 104);
    @(negedge clk); cfg_rst_en = 1'b1;
    @(negedge clk);
    check("R6 cleared", count, 0);
    check("R6 evt_reset", {31'd0, evt_reset}, 1);
    @(negedge clk);
    check("R6 evt one cycle", {31'd0, evt_reset}, 0);
    pins(1'b1, 1'b0); pins(1'b0, 1'b0);
    check("R6 held", count, 0);
    send(4'd1, 0, 1, 0, 16'h0001, 32'd5, 0);
    check("R9 busy", {16'd0, rsp_status}, 32'h80C0);
    check("R9 busy no load", count, 0);
    @(negedge clk); in_rst = 1'b0;
    pins(1'b1, 1'b0); pins(1'b0, 1'b0);
    check("R6 resumes", count, 1);
    // R10 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    send(4'd2, 0, 0, 0, 16'h0001, 0, 0);
    check("R10 held valid", {31'd0, rsp_valid}, 1);
    check("R10 not ready", {31'd0, cmd_ready}, 0);
    cmd_id = 4'd1; cmd_set_cnt = 1'b1; cmd_cnt = 32'd99; cmd_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 blocked cmd", count, 1);
    check("R10 status stable", {16'd0, rsp_status}, 32'h80A1);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", {31'd0, rsp_valid}, 0);
    check("R10 ready again", {31'd0, cmd_ready}, 1);
    // R3 pin direction mode
    @(negedge clk); cfg_mode = 2'd1;
    pins(1'b1, 1'b1); check("R3 up", count, 2);
    pins(1'b0, 1'b1);
    pins(1'b1, 1'b0); check("R3 down", count, 1);
    check("R3 dir", {31'd0, count_up}, 0);
    check("R12 evt_dir pin", {31'd0, evt_dir}, 1);
    pins(1'b0, 1'b0);
    send(4'd1, 1, 0, 0, 16'h0001, 0, 0);
    check("R8 non-sw status", {16'd0, rsp_status}, 0);
    check("R8 non-sw no dir", {31'd0, count_up}, 0);
    // R4 up/down clocks
    @(negedge clk); cfg_mode = 2'd2;
    send(4'd1, 0, 1, 0, 16'h0001, 32'd10, 0);
    pins(1'b1, 1'b0); check("R4 up", count, 11);
    pins(1'b0, 1'b0);
    pins(1'b0, 1'b1); check("R4 down", count, 10);
    pins(1'b0, 1'b0);
    pins(1'b1, 1'b1); check("R4 cancel", count, 10);
    pins(1'b0, 1'b0); check("R4 fall", count, 10);
    // R13 wrap
    send(4'd1, 0, 1, 0, 16'h0001, 32'h7FFFFFFF, 0);
    pins(1'b1, 1'b0); pins(1'b0, 1'b0);
    check("R13 wrap up", count, 32'h80000000);
    pins(1'b0, 1'b1); pins(1'b0, 1'b0);
    check("R13 wrap back", count, 32'h7FFFFFFF);
    send(4'd1, 0, 1, 0, 16'h0001, 32'd0, 0);
    pins(1'b0, 1'b1); pins(1'b0, 1'b0);
    check("R13 below zero", count, 32'hFFFFFFFF);
    // R5 quadrature, all transitions
    @(negedge clk); cfg_mode = 2'd3;
    send(4'd1, 0, 1, 0, 16'h0001, 32'd1000, 0);
    expc = 32'd1000;
    cur_ab = 2'b00;
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        for (int k = 0; k < 2; k++) begin
          logic [1:0] nxt;
          logic [1:0] dd;
          nxt = (k == 0) ? 2'(s) : 2'(t);
          dd = qidx(nxt) - qidx(cur_ab);
          if (dd == 2'd1) expc = expc + 32'd1;
          else if (dd == 2'd3) expc = expc - 32'd1;
          pins(nxt[1], nxt[0]);
          cur_ab = nxt;
          check("R5 quad step", count, expc);
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule